// File: doc/BRIEF.md
# Packed-Integer Instruction Fault Classifier

This block decides whether one packed-integer SIMD instruction must be stopped by an exception before it executes. It looks at the control-register enables, the SSE2 feature bit, the lock-prefix flag, the operand width (64-bit register form or 128-bit form), the operating mode, the current privilege level and the attributes of the memory operand. It reports at most one fault, chosen by a fixed priority, as a 3-bit code with a separate valid bit.

The decode stage pulses `req_i` for one cycle with all inputs steady. In the next cycle `done_o` is high, `fault_o` tells whether any fault applies and `code_o` names the winning fault. Page-fault detection and address translation stay with the memory pipeline. The segment-limit and canonical-form results arrive as ready-made flags. Only the effective-address offset is checked here, for alignment and for the 16-bit wrap.

Top module: `simd_fault_unit`

## Requirements
- R1: Fault codes are NONE=0, UD (invalid opcode)=1, NM (device not available)=2, GP (general protection)=3, SS (stack fault)=4, MF (x87 math fault)=5 and AC (alignment check)=6. `mode_i` uses real=0, virtual-8086=1, protected=2, compatibility=3, 64-bit=4. `wide_i`=1 selects the 128-bit form.
- R2: UD is raised whenever `cr0_em_i` is set or `lock_i` is set, for both widths and in every mode.
- R3: For the 128-bit form, UD is also raised when `cr4_fxsr_i` is clear in any mode, and when `sse2_i` is clear in every mode other than 64-bit.
- R4: NM is raised whenever `cr0_ts_i` is set.
- R5: For a 128-bit memory operand (`mem_i`=1), GP is raised in every mode when `ea_i[3:0]` is not zero.
- R6: In 64-bit mode, a memory operand with `canon_i`=0 raises SS when `stack_i`=1 and GP otherwise. In protected and compatibility mode, `seg_viol_i`=1 on a memory operand raises SS when `stack_i`=1 and GP otherwise.
- R7: In real and virtual-8086 mode, a memory operand raises GP when its last byte, `ea_i` + 7 for the 64-bit form or `ea_i` + 15 for the 128-bit form, lies above 0xFFFF.
- R8: For the 64-bit form only, `x87_pend_i` raises MF.
- R9: For the 64-bit form only, a memory operand with `ac_en_i`=1 and `ea_i[2:0]` not zero raises AC. This happens in virtual-8086 mode at any privilege level, and in protected, compatibility and 64-bit mode only when `cpl_i`=3. It never happens in real mode.
- R10: When several faults apply, UD wins over NM, NM wins over GP, GP wins over SS, SS wins over MF and MF wins over AC. Without a memory operand no GP, SS or AC is reported.
- R11: The result is registered. The cycle after `req_i`=1 shows `done_o`=1 and `fault_o`=1 exactly when `code_o`≠0. The cycle after `req_i`=0, and the first cycle after reset, show all three outputs at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Check request, one cycle |
| mode_i | input | 3 | Operating mode (R1 encoding) |
| cpl_i | input | 2 | Current privilege level |
| cr0_em_i | input | 1 | Emulation enable bit |
| cr0_ts_i | input | 1 | Task-switched bit |
| cr4_fxsr_i | input | 1 | OS support for extended state save |
| sse2_i | input | 1 | SSE2 feature bit |
| lock_i | input | 1 | Lock prefix present |
| wide_i | input | 1 | 1 = 128-bit form, 0 = 64-bit form |
| mem_i | input | 1 | Source is a memory operand |
| ea_i | input | EA_W | Effective-address offset |
| seg_viol_i | input | 1 | Segment-limit violation flag |
| canon_i | input | 1 | Address is in canonical form |
| stack_i | input | 1 | Reference uses the stack segment |
| ac_en_i | input | 1 | Alignment checking enabled |
| x87_pend_i | input | 1 | x87 exception pending |
| done_o | output | 1 | Result valid this cycle |
| fault_o | output | 1 | A fault is reported |
| code_o | output | 3 | Winning fault code (R1) |

## Verification
The bench targets cases where a rule must be limited to one width or one mode. It tries SSE2 clear in 64-bit mode, which must pass, and MF or AC on the 128-bit form, which must be suppressed. A design that drops the width qualifier shows up as a spurious MF or AC code. Offsets just below and just above the 0xFFFF wrap for both operand sizes catch an off-by-one in the span sum. AC is tried at privilege levels 0 and 3 in virtual-8086 mode and in protected mode, which exposes a swapped privilege rule. Stacked faults show whether the priority chain is ordered correctly.

// File: rtl/simd_fault_pkg.sv
package simd_fault_pkg;

    typedef enum logic [2:0] {
        MD_REAL   = 3'd0,
        MD_V86    = 3'd1,
        MD_PROT   = 3'd2,
        MD_COMPAT = 3'd3,
        MD_LONG   = 3'd4
    } cpu_mode_e;

    typedef enum logic [2:0] {
        FC_NONE = 3'd0,
        FC_UD   = 3'd1,
        FC_NM   = 3'd2,
        FC_GP   = 3'd3,
        FC_SS   = 3'd4,
        FC_MF   = 3'd5,
        FC_AC   = 3'd6
    } fault_code_e;

    // one flag per fault class, collected from the sub-checkers
    typedef struct packed {
        logic ud;
        logic nm;
        logic gp;
        logic ss;
        logic mf;
        logic ac;
    } fault_vec_t;

    typedef struct packed {
        logic        valid;
        logic        fault;
        fault_code_e code;
    } fault_rsp_t;

    function automatic fault_code_e pick_fault(input fault_vec_t v);
        fault_code_e c;
        c = FC_NONE;
        if (v.ud)      c = FC_UD;
        else if (v.nm) c = FC_NM;
        else if (v.gp) c = FC_GP;
        else if (v.ss) c = FC_SS;
        else if (v.mf) c = FC_MF;
        else if (v.ac) c = FC_AC;
        return c;
    endfunction

    function automatic logic mode_is_16bit(input cpu_mode_e m);
        return (m == MD_REAL) || (m == MD_V86);
    endfunction

    function automatic logic mode_is_segmented(input cpu_mode_e m);
        return (m == MD_PROT) || (m == MD_COMPAT);
    endfunction

endpackage

// File: rtl/simd_gate_check.sv
module simd_gate_check
    import simd_fault_pkg::*;
(
    input  cpu_mode_e mode,
    input  logic      em,
    input  logic      ts,
    input  logic      fxsr,
    input  logic      sse2,
    input  logic      lock_pfx,
    input  logic      wide,
    output logic      ud,
    output logic      nm
);
    logic wide_blocked;

    always_comb begin
        wide_blocked = wide && (!fxsr || (!sse2 && (mode != MD_LONG)));
        ud           = em || lock_pfx || wide_blocked;
        nm           = ts;
    end
endmodule

// File: rtl/simd_mem_check.sv
module simd_mem_check
    import simd_fault_pkg::*;
#(
    parameter int EA_W         = 32,
    parameter int WIDE_BYTES   = 16,
    parameter int NARROW_BYTES = 8,
    parameter int SEG16_LAST   = 'hFFFF
) (
    input  cpu_mode_e         mode,
    input  logic              mem,
    input  logic              wide,
    input  logic [EA_W-1:0]   ea,
    input  logic              seg_viol,
    input  logic              canon,
    input  logic              stack,
    output logic              gp,
    output logic              ss
);
    localparam int WIDE_LSB = $clog2(WIDE_BYTES);
    localparam logic [EA_W:0] WIDE_TAIL   = (EA_W+1)'(WIDE_BYTES - 1);
    localparam logic [EA_W:0] NARROW_TAIL = (EA_W+1)'(NARROW_BYTES - 1);
    localparam logic [EA_W:0] LAST_OFF    = (EA_W+1)'(SEG16_LAST);

    logic [EA_W:0] last_byte;
    logic          misalign, wrap16, limit_hit;

    always_comb begin
        last_byte = {1'b0, ea} + (wide ? WIDE_TAIL : NARROW_TAIL);
        misalign  = wide && (ea[WIDE_LSB-1:0] != '0);
        wrap16    = mode_is_16bit(mode) && (last_byte > LAST_OFF);
        limit_hit = (mode == MD_LONG) ? !canon
                  : mode_is_segmented(mode) ? seg_viol
                  : 1'b0;
        gp = mem && (misalign || wrap16 || (limit_hit && !stack));
        ss = mem && limit_hit && stack;
    end
endmodule

// File: rtl/simd_legacy_check.sv
module simd_legacy_check
    import simd_fault_pkg::*;
#(
    parameter int EA_W         = 32,
    parameter int NARROW_BYTES = 8,
    parameter int USER_CPL     = 3
) (
    input  cpu_mode_e       mode,
    input  logic [1:0]      cpl,
    input  logic            wide,
    input  logic            mem,
    input  logic            ac_en,
    input  logic            x87_pend,
    input  logic [EA_W-1:0] ea,
    output logic            mf,
    output logic            ac
);
    localparam int NARROW_LSB = $clog2(NARROW_BYTES);
    localparam logic [1:0] USER_LVL = 2'(USER_CPL);

    logic ring_ok;

    always_comb begin
        case (mode)
            MD_V86:                      ring_ok = 1'b1;
            MD_PROT, MD_COMPAT, MD_LONG: ring_ok = (cpl == USER_LVL);
            default:                     ring_ok = 1'b0;
        endcase
        mf = !wide && x87_pend;
        ac = !wide && mem && ac_en && ring_ok && (ea[NARROW_LSB-1:0] != '0);
    end
endmodule

// File: rtl/simd_fault_unit.sv
module simd_fault_unit
    import simd_fault_pkg::*;
#(
    parameter int EA_W         = 32,
    parameter int WIDE_BYTES   = 16,
    parameter int NARROW_BYTES = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_i,
    input  logic [2:0]      mode_i,
    input  logic [1:0]      cpl_i,
    input  logic            cr0_em_i,
    input  logic            cr0_ts_i,
    input  logic            cr4_fxsr_i,
    input  logic            sse2_i,
    input  logic            lock_i,
    input  logic            wide_i,
    input  logic            mem_i,
    input  logic [EA_W-1:0] ea_i,
    input  logic            seg_viol_i,
    input  logic            canon_i,
    input  logic            stack_i,
    input  logic            ac_en_i,
    input  logic            x87_pend_i,
    output logic            done_o,
    output logic            fault_o,
    output logic [2:0]      code_o
);
    cpu_mode_e   mode;
    fault_vec_t  fv;
    fault_code_e win;
    fault_rsp_t  rsp_q;

    assign mode = cpu_mode_e'(mode_i);

    simd_gate_check u_gate (
        .mode     (mode),
        .em       (cr0_em_i),
        .ts       (cr0_ts_i),
        .fxsr     (cr4_fxsr_i),
        .sse2     (sse2_i),
        .lock_pfx (lock_i),
        .wide     (wide_i),
        .ud       (fv.ud),
        .nm       (fv.nm)
    );

    simd_mem_check #(
        .EA_W         (EA_W),
        .WIDE_BYTES   (WIDE_BYTES),
        .NARROW_BYTES (NARROW_BYTES)
    ) u_mem (
        .mode     (mode),
        .mem      (mem_i),
        .wide     (wide_i),
        .ea       (ea_i),
        .seg_viol (seg_viol_i),
        .canon    (canon_i),
        .stack    (stack_i),
        .gp       (fv.gp),
        .ss       (fv.ss)
    );

    simd_legacy_check #(
        .EA_W         (EA_W),
        .NARROW_BYTES (NARROW_BYTES)
    ) u_legacy (
        .mode     (mode),
        .cpl      (cpl_i),
        .wide     (wide_i),
        .mem      (mem_i),
        .ac_en    (ac_en_i),
        .x87_pend (x87_pend_i),
        .ea       (ea_i),
        .mf       (fv.mf),
        .ac       (fv.ac)
    );

    assign win = pick_fault(fv);

    always_ff @(posedge clk) begin
        if (rst || !req_i) begin
            rsp_q <= '{valid: 1'b0, fault: 1'b0, code: FC_NONE};
        end else begin
            rsp_q <= '{valid: 1'b1, fault: (win != FC_NONE), code: win};
        end
    end

    assign done_o  = rsp_q.valid;
    assign fault_o = rsp_q.fault;
    assign code_o  = rsp_q.code;
endmodule

// File: rtl/simd_fault_unit_sva.sv
module simd_fault_unit_sva #(
    parameter int EA_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            req_i,
    input logic [2:0]      mode_i,
    input logic            cr0_em_i,
    input logic            cr0_ts_i,
    input logic            lock_i,
    input logic            wide_i,
    input logic            mem_i,
    input logic [EA_W-1:0] ea_i,
    input logic            x87_pend_i,
    input logic            done_o,
    input logic            fault_o,
    input logic [2:0]      code_o
);
    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> (!done_o && !fault_o && code_o == 3'd0));

    // R11
    done_follow_chk: assert property (@(posedge clk) disable iff (rst)
        req_i |=> done_o);

    // R11
    fault_code_match_chk: assert property (@(posedge clk) disable iff (rst)
        fault_o == (code_o != 3'd0));

    // R1
    code_range_chk: assert property (@(posedge clk) disable iff (rst)
        code_o <= 3'd6);

    // R2
    ud_on_em_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (req_i && (cr0_em_i || lock_i)) |=> (code_o == 3'd1));

    // R4
    nm_or_higher_chk: assert property (@(posedge clk) disable iff (rst)
        (req_i && cr0_ts_i) |=> (code_o == 3'd1 || code_o == 3'd2));

    // R8
    wide_no_mf_chk: assert property (@(posedge clk) disable iff (rst)
        (req_i && wide_i) |=> (code_o != 3'd5 && code_o != 3'd6));

    // R10
    reg_no_mem_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (req_i && !mem_i) |=> (code_o != 3'd3 && code_o != 3'd4 && code_o != 3'd6));

    // R5
    wide_misalign_chk: assert property (@(posedge clk) disable iff (rst)
        (req_i && wide_i && mem_i && ea_i[3:0] != 4'd0 && !cr0_em_i && !lock_i && !cr0_ts_i)
        |=> (code_o == 3'd1 || code_o == 3'd3));

    // R8
    mf_on_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (req_i && !wide_i && x87_pend_i) |=> (code_o != 3'd0 && code_o != 3'd6));
endmodule

bind simd_fault_unit simd_fault_unit_sva #(.EA_W(EA_W)) u_sva (
    .clk        (clk),
    .rst        (rst),
    .req_i      (req_i),
    .mode_i     (mode_i),
    .cr0_em_i   (cr0_em_i),
    .cr0_ts_i   (cr0_ts_i),
    .lock_i     (lock_i),
    .wide_i     (wide_i),
    .mem_i      (mem_i),
    .ea_i       (ea_i),
    .x87_pend_i (x87_pend_i),
    .done_o     (done_o),
    .fault_o    (fault_o),
    .code_o     (code_o)
);

// File: tb/sim_simd_fault_unit.sv
module sim_simd_fault_unit;
    localparam int CLK_PERIOD = 10;
    localparam int EA_W = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_i = 1'b0;
    logic [2:0] mode_i = 3'd2;
    logic [1:0] cpl_i = 2'd0;
    logic cr0_em_i = 0, cr0_ts_i = 0, cr4_fxsr_i = 1, sse2_i = 1, lock_i = 0;
    logic wide_i = 0, mem_i = 0, seg_viol_i = 0, canon_i = 1, stack_i = 0;
    logic ac_en_i = 0, x87_pend_i = 0;
    logic [EA_W-1:0] ea_i = '0;
    logic done_o, fault_o;
    logic [2:0] code_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_fault_unit u0 (
        .clk(clk), .rst(rst), .req_i(req_i), .mode_i(mode_i), .cpl_i(cpl_i),
        .cr0_em_i(cr0_em_i), .cr0_ts_i(cr0_ts_i), .cr4_fxsr_i(cr4_fxsr_i),
        .sse2_i(sse2_i), .lock_i(lock_i), .wide_i(wide_i), .mem_i(mem_i),
        .ea_i(ea_i), .seg_viol_i(seg_viol_i), .canon_i(canon_i),
        .stack_i(stack_i), .ac_en_i(ac_en_i), .x87_pend_i(x87_pend_i),
        .done_o(done_o), .fault_o(fault_o), .code_o(code_o)
    );

    // behavioural model of the rules, written from the requirements
    function automatic int model_code();
        longint last;
        int size;
        bit long_m, seg_m, legacy_m, user_ok;
        size     = wide_i ? 16 : 8;
        last     = longint'(ea_i) + size - 1;
        long_m   = (mode_i == 3'd4);
        seg_m    = (mode_i == 3'd2) || (mode_i == 3'd3);
        legacy_m = (mode_i == 3'd0) || (mode_i == 3'd1);
        if (cr0_em_i || lock_i) return 1;
        if (wide_i && !cr4_fxsr_i) return 1;
        if (wide_i && !sse2_i && !long_m) return 1;
        if (cr0_ts_i) return 2;
        if (mem_i) begin
            if (wide_i && (ea_i % 16) != 0) return 3;
            if (legacy_m && last > 65535) return 3;
            if (long_m && !canon_i) return stack_i ? 4 : 3;
            if (seg_m && seg_viol_i) return stack_i ? 4 : 3;
        end
        if (!wide_i && x87_pend_i) return 5;
        user_ok = (mode_i == 3'd1) || ((seg_m || long_m) && cpl_i == 2'd3);
        if (!wide_i && mem_i && ac_en_i && (ea_i % 8) != 0 && user_ok) return 6;
        return 0;
    endfunction

    task automatic compare(input string tag, input int e_done, input int e_fault, input int e_code);
        checks++;
        if (done_o !== 1'(e_done) || fault_o !== 1'(e_fault) || code_o !== 3'(e_code)) begin
            errors++;
            $display("FAIL %s: actual done=%0d fault=%0d code=%0d expected done=%0d fault=%0d code=%0d",
                     tag, done_o, fault_o, code_o, e_done, e_fault, e_code);
        end
    endtask

    // inputs are already set; the result appears after the next rising edge
    task automatic step(input string tag);
        int c, r;
        c = model_code();
        r = req_i;
        @(negedge clk);
        compare(tag, r, (r != 0 && c != 0) ? 1 : 0, r != 0 ? c : 0);
    endtask

    task automatic clear_inputs();
        req_i = 1; mode_i = 3'd2; cpl_i = 0; cr0_em_i = 0; cr0_ts_i = 0;
        cr4_fxsr_i = 1; sse2_i = 1; lock_i = 0; wide_i = 0; mem_i = 0;
        seg_viol_i = 0; canon_i = 1; stack_i = 0; ac_en_i = 0; x87_pend_i = 0;
        ea_i = '0;
    endtask

    task automatic expect_code(input string tag, input int code);
        int r;
        r = model_code();
        if (r != code) begin
            errors++; checks++;
            $display("FAIL %s: model code=%0d expected code=%0d", tag, r, code);
        end
        step(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R11 reset state
        compare("R11 reset", 0, 0, 0);

        clear_inputs(); expect_code("R11 clean", 0);
        req_i = 0; cr0_em_i = 1; step("R11 idle");

        clear_inputs(); cr0_em_i = 1; expect_code("R2 em", 1);
        clear_inputs(); lock_i = 1; wide_i = 1; mode_i = 3'd4; expect_code("R2 lock", 1);
        clear_inputs(); wide_i = 1; cr4_fxsr_i = 0; mode_i = 3'd4; expect_code("R3 fxsr", 1);
        clear_inputs(); wide_i = 1; sse2_i = 0; mode_i = 3'd3; expect_code("R3 sse2", 1);
        clear_inputs(); wide_i = 1; sse2_i = 0; mode_i = 3'd4; expect_code("R3 sse2 long", 0);
        clear_inputs(); sse2_i = 0; expect_code("R3 narrow", 0);
        clear_inputs(); cr0_ts_i = 1; expect_code("R4 ts", 2);
        clear_inputs(); wide_i = 1; mem_i = 1; ea_i = 32'h108; mode_i = 3'd4; expect_code("R5 misalign", 3);
        clear_inputs(); wide_i = 1; mem_i = 1; ea_i = 32'h110; expect_code("R5 aligned", 0);
        clear_inputs(); mode_i = 3'd4; mem_i = 1; canon_i = 0; stack_i = 1; expect_code("R6 ss long", 4);
        clear_inputs(); mode_i = 3'd4; mem_i = 1; canon_i = 0; expect_code("R6 gp long", 3);
        clear_inputs(); mode_i = 3'd3; mem_i = 1; seg_viol_i = 1; stack_i = 1; expect_code("R6 ss compat", 4);
        clear_inputs(); mode_i = 3'd2; mem_i = 1; seg_viol_i = 1; expect_code("R6 gp prot", 3);
        clear_inputs(); mode_i = 3'd4; mem_i = 1; seg_viol_i = 1; expect_code("R6 long ignores limit", 0);
        clear_inputs(); mode_i = 3'd0; mem_i = 1; ea_i = 32'hFFF8; expect_code("R7 narrow edge", 0);
        clear_inputs(); mode_i = 3'd0; mem_i = 1; ea_i = 32'hFFF9; ac_en_i = 1; cpl_i = 3; expect_code("R7 narrow over", 3);
        clear_inputs(); mode_i = 3'd1; mem_i = 1; wide_i = 1; ea_i = 32'hFFF0; expect_code("R7 wide edge", 0);
        clear_inputs(); mode_i = 3'd1; mem_i = 1; ea_i = 32'h1FFF8; expect_code("R7 v86 over", 3);
        clear_inputs(); x87_pend_i = 1; expect_code("R8 mf", 5);
        clear_inputs(); x87_pend_i = 1; wide_i = 1; expect_code("R8 wide", 0);
        clear_inputs(); mem_i = 1; ac_en_i = 1; ea_i = 32'h3; cpl_i = 3; expect_code("R9 prot cpl3", 6);
        clear_inputs(); mem_i = 1; ac_en_i = 1; ea_i = 32'h3; cpl_i = 0; expect_code("R9 prot cpl0", 0);
        clear_inputs(); mode_i = 3'd1; mem_i = 1; ac_en_i = 1; ea_i = 32'h5; expect_code("R9 v86 cpl0", 6);
        clear_inputs(); mode_i = 3'd0; mem_i = 1; ac_en_i = 1; ea_i = 32'h5; cpl_i = 3; expect_code("R9 real", 0);
        clear_inputs(); mem_i = 1; ac_en_i = 1; ea_i = 32'h8; cpl_i = 3; expect_code("R9 aligned", 0);
        clear_inputs(); wide_i = 1; mem_i = 1; ac_en_i = 1; ea_i = 32'h10; cpl_i = 3; expect_code("R9 wide", 0);
        clear_inputs(); cr0_ts_i = 1; lock_i = 1; expect_code("R10 ud over nm", 1);
        clear_inputs(); cr0_ts_i = 1; mem_i = 1; seg_viol_i = 1; expect_code("R10 nm over gp", 2);
        clear_inputs(); mode_i = 3'd4; wide_i = 1; mem_i = 1; ea_i = 32'h4; canon_i = 0; stack_i = 1; expect_code("R10 gp over ss", 3);
        clear_inputs(); mem_i = 1; seg_viol_i = 1; stack_i = 1; x87_pend_i = 1; expect_code("R10 ss over mf", 4);
        clear_inputs(); x87_pend_i = 1; mem_i = 1; ac_en_i = 1; ea_i = 32'h1; cpl_i = 3; expect_code("R10 mf over ac", 5);
        clear_inputs(); seg_viol_i = 1; canon_i = 0; ac_en_i = 1; ea_i = 32'h1; cpl_i = 3; expect_code("R10 no mem", 0);

        // mixed traffic, compared on every clock
        for (int i = 0; i < 4000; i++) begin
            req_i      = ($urandom % 4) != 0;
            mode_i     = 3'($urandom % 5);
            cpl_i      = 2'($urandom);
            cr0_em_i   = ($urandom % 8) == 0;
            cr0_ts_i   = ($urandom % 8) == 0;
            lock_i     = ($urandom % 8) == 0;
            cr4_fxsr_i = ($urandom % 6) != 0;
            sse2_i     = ($urandom % 6) != 0;
            wide_i     = 1'($urandom);
            mem_i      = 1'($urandom);
            seg_viol_i = ($urandom % 4) == 0;
            canon_i    = ($urandom % 4) != 0;
            stack_i    = 1'($urandom);
            ac_en_i    = 1'($urandom);
            x87_pend_i = ($urandom % 4) == 0;
            case ($urandom % 3)
                0: ea_i = 32'hFFF0 + 32'($urandom % 16);
                1: ea_i = $urandom & 32'hFFFF_FFF0;
                default: ea_i = $urandom;
            endcase
            step("R10 mixed");
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL R11 watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule